// File: doc/BRIEF.md
# Filtered Event Counter Group

This block is a group of four 32-bit performance counters that share one stream filter. On every clock the surrounding logic presents a vector of event pulses, and each pulse carries the stream identifier of the transaction that raised it. Each counter has an event-select field and an enable bit. When a counter is enabled and the event it selects is qualified in a cycle, the counter adds one. An event is qualified when its pulse is high, when it passes the shared stream filter (this applies only to filterable events), and when, for a secure-only event, the secure-observation bit is set. Event code 0 is the clock-cycle event. It is raised inside the block on every cycle in which the clock-gated indication is low.

Software reaches the group through a simple register port. The write side takes effect at the next clock edge. A read returns data one cycle after it is requested. A capture strobe copies all four counters into their shadow registers at the same edge, so the four snapshots are coherent with each other. Each counter wraps silently past its maximum value and sets a sticky overflow flag. Software clears that flag by writing 1 to its bit.

Register word addresses: 0 to 3 are the counters (read/write). 4 to 7 are the event selects, with the code in bits [3:0]. 8 holds the enables, with bit n for counter n. 9 holds the overflow flags, where bit n belongs to counter n and writing 1 clears it. 10 is the filter: match value in bits [7:0], match-all in bit 8. 11 is control: capture strobe in bit 0, secure-observation in bit 1. 12 to 15 are the shadows (read-only).

Top module: `evt_cnt_group`

## Requirements
- R1: After reset every counter, shadow, event select, enable, overflow flag, filter field and control bit reads as 0.
- R2: A counter adds exactly one on each clock edge where its enable bit (address 8, bit n) is 1 and the event coded in its select field is qualified. A disabled counter holds its value.
- R3: Event code 0 qualifies on every cycle in which clk_gated is low and never while it is high. The stream filter does not apply to it.
- R4: Event codes 1 to 7 are filterable. Such an event qualifies only if the match-all bit (address 10, bit 8) is 1 or if its stream identifier equals the match value (address 10, bits [7:0]). The same filter applies to every counter.
- R5: Event codes 8 to 15 count whatever the filter setting.
- R6: Event codes 12 to 15 are secure-only. They qualify only while the secure-observation bit (address 11, bit 1) is 1.
- R7: A counter at 0xFFFF_FFFF that increments becomes 0 and sets its overflow flag (address 9, bit n). The flag stays set until 1 is written to that bit. If a wrap and a clearing write happen at the same edge, the flag ends up set.
- R8: A software write to a counter wins over an increment at the same edge.
- R9: Writing 1 to address 11 bit 0 copies each counter's value, as held just before that edge, into its shadow (addresses 12 to 15), all at the same edge. At any other time the shadows keep their values.
- R10: The capture bit always reads back as 0.
- R11: rd_data and rd_valid are driven one cycle after rd_en is sampled high. rd_valid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | 15 | Event pulses for codes 1 to 15 (bit k is code k) |
| evt_sid | input | 120 | Stream identifiers, 8 bits per event, bits [8k+7:8k] for code k |
| clk_gated | input | 1 | High in cycles where the clock counts as gated |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Read data, valid one cycle after the request |
| rd_valid | output | 1 | High in the cycle that rd_data holds a result |

## Verification
An event that is qualified in a cycle shows up in its counter at the next edge. A configuration write takes effect at the edge that samples it, so it governs only the events of the cycles that follow. The bench drives all inputs at falling edges and leaves at least one full cycle between a stimulus and the read that observes it. Each read's expected value is queued at the request and compared at the falling edge after the next rising edge, which is exactly when rd_valid must be high. Same-edge interactions (capture with an increment, a counter write with an increment, a flag clear with a wrap) are driven in a single cycle, and their outcome is read back afterwards.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;

  // Stream filter test: match-all or exact identifier equality
  function automatic logic sid_pass(input logic span_all,
                                    input logic [7:0] match_sid,
                                    input logic [7:0] sid);
    return span_all || (sid == match_sid);
  endfunction

  // Counter step: returns {carry, value + 1}
  function automatic logic [32:0] step_count(input logic [31:0] cur);
    return {1'b0, cur} + 33'd1;
  endfunction

endpackage

// File: rtl/evt_qualify.sv
module evt_qualify
  import evt_cnt_pkg::*;
#(
  parameter int unsigned NUM_EVT   = 16,
  parameter int unsigned SID_W     = 8,
  parameter logic [15:0] FILT_MASK = 16'h00FE,
  parameter logic [15:0] SEC_MASK  = 16'hF000
) (
  input  logic [NUM_EVT-1:1]       evt_pulse,
  input  logic [NUM_EVT*SID_W-1:SID_W] evt_sid,
  input  logic                     clk_gated,
  input  logic                     span_all,
  input  logic [SID_W-1:0]         match_sid,
  input  logic                     sec_obs,
  output logic [NUM_EVT-1:0]       evt_qual
);

  // Code 0: cycle event, suppressed while the clock is gated
  assign evt_qual[0] = !clk_gated;

  for (genvar e = 1; e < NUM_EVT; e++) begin : g_evt
    logic filt_ok;
    logic sec_ok;
    if (FILT_MASK[e]) begin : g_filt
      assign filt_ok = sid_pass(span_all, match_sid, evt_sid[e*SID_W +: SID_W]);
    end else begin : g_nofilt
      assign filt_ok = 1'b1;
    end
    if (SEC_MASK[e]) begin : g_sec
      assign sec_ok = sec_obs;
    end else begin : g_nosec
      assign sec_ok = 1'b1;
    end
    assign evt_qual[e] = evt_pulse[e] && filt_ok && sec_ok;
  end

endmodule

// File: rtl/ctr_slice.sv
module ctr_slice
  import evt_cnt_pkg::*;
#(
  parameter int unsigned NUM_EVT = 16,
  parameter int unsigned CTR_W   = 32,
  localparam int unsigned SEL_W  = $clog2(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_EVT-1:0] evt_qual,
  input  logic               wr_hit,
  input  logic [CTR_W-1:0]   wr_val,
  input  logic               ovf_clr,
  input  logic               cap,
  output logic [CTR_W-1:0]   count,
  output logic [CTR_W-1:0]   shadow,
  output logic               ovf,
  output logic               inc,
  output logic               wrap
);

  logic [CTR_W:0] nxt;

  assign inc  = enable && evt_qual[sel];
  assign nxt  = step_count(count);
  assign wrap = inc && !wr_hit && nxt[CTR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (wr_hit) begin
      count <= wr_val;
    end else if (inc) begin
      count <= nxt[CTR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf <= 1'b0;
    end else if (wrap) begin
      ovf <= 1'b1;
    end else if (ovf_clr) begin
      ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
    end else if (cap) begin
      shadow <= count;
    end
  end

endmodule

// File: rtl/evt_cnt_group.sv
module evt_cnt_group
  import evt_cnt_pkg::*;
#(
  parameter int unsigned NUM_CTR   = 4,
  parameter int unsigned NUM_EVT   = 16,
  parameter int unsigned SID_W     = 8,
  parameter int unsigned CTR_W     = 32,
  parameter logic [15:0] FILT_MASK = 16'h00FE,
  parameter logic [15:0] SEC_MASK  = 16'hF000,
  localparam int unsigned SEL_W    = $clog2(NUM_EVT),
  localparam int unsigned A_SEL    = NUM_CTR,
  localparam int unsigned A_EN     = 2 * NUM_CTR,
  localparam int unsigned A_OVF    = A_EN + 1,
  localparam int unsigned A_FILT   = A_EN + 2,
  localparam int unsigned A_CTRL   = A_EN + 3,
  localparam int unsigned A_SHD    = A_EN + 4,
  localparam int unsigned AW       = $clog2(A_SHD + NUM_CTR)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_EVT-1:1]           evt_pulse,
  input  logic [NUM_EVT*SID_W-1:SID_W] evt_sid,
  input  logic                         clk_gated,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [CTR_W-1:0]             wr_data,
  input  logic                         rd_en,
  input  logic [AW-1:0]                rd_addr,
  output logic [CTR_W-1:0]             rd_data,
  output logic                         rd_valid
);

  // Configuration state
  logic [SEL_W-1:0] evsel [NUM_CTR];
  logic [NUM_CTR-1:0] ctr_en;
  logic               span_all;
  logic [SID_W-1:0]   match_sid;
  logic               sec_obs;

  // Named internal events, exported for the checker
  logic [NUM_EVT-1:0] evt_qual;
  logic [NUM_CTR-1:0] ctr_inc;
  logic [NUM_CTR-1:0] ctr_wrap;
  logic [NUM_CTR-1:0] ovf_flag;
  logic [NUM_CTR-1:0] ctr_wr_hit;
  logic [NUM_CTR-1:0] ovf_clr;
  logic               cap_fire;
  logic [CTR_W-1:0]   count  [NUM_CTR];
  logic [CTR_W-1:0]   shadow [NUM_CTR];

  assign cap_fire = wr_en && (wr_addr == AW'(A_CTRL)) && wr_data[0];

  evt_qualify #(
    .NUM_EVT(NUM_EVT), .SID_W(SID_W), .FILT_MASK(FILT_MASK), .SEC_MASK(SEC_MASK)
  ) u_qual (
    .evt_pulse(evt_pulse), .evt_sid(evt_sid), .clk_gated(clk_gated),
    .span_all(span_all), .match_sid(match_sid), .sec_obs(sec_obs),
    .evt_qual(evt_qual)
  );

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    assign ctr_wr_hit[n] = wr_en && (wr_addr == AW'(n));
    assign ovf_clr[n]    = wr_en && (wr_addr == AW'(A_OVF)) && wr_data[n];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        evsel[n] <= '0;
      end else if (wr_en && (wr_addr == AW'(A_SEL + n))) begin
        evsel[n] <= wr_data[SEL_W-1:0];
      end
    end

    ctr_slice #(.NUM_EVT(NUM_EVT), .CTR_W(CTR_W)) u_slice (
      .clk(clk), .rst_n(rst_n), .enable(ctr_en[n]), .sel(evsel[n]),
      .evt_qual(evt_qual), .wr_hit(ctr_wr_hit[n]), .wr_val(wr_data),
      .ovf_clr(ovf_clr[n]), .cap(cap_fire), .count(count[n]),
      .shadow(shadow[n]), .ovf(ovf_flag[n]), .inc(ctr_inc[n]),
      .wrap(ctr_wrap[n])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_en    <= '0;
      span_all  <= 1'b0;
      match_sid <= '0;
      sec_obs   <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == AW'(A_EN))   ctr_en <= wr_data[NUM_CTR-1:0];
      if (wr_addr == AW'(A_FILT)) begin
        match_sid <= wr_data[SID_W-1:0];
        span_all  <= wr_data[SID_W];
      end
      if (wr_addr == AW'(A_CTRL)) sec_obs <= wr_data[1];
    end
  end

  // Read mux
  logic [CTR_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    for (int n = 0; n < NUM_CTR; n++) begin
      if (rd_addr == AW'(n))         rd_mux = count[n];
      if (rd_addr == AW'(A_SEL + n)) rd_mux = CTR_W'(evsel[n]);
      if (rd_addr == AW'(A_SHD + n)) rd_mux = shadow[n];
    end
    if (rd_addr == AW'(A_EN))   rd_mux = CTR_W'(ctr_en);
    if (rd_addr == AW'(A_OVF))  rd_mux = CTR_W'(ovf_flag);
    if (rd_addr == AW'(A_FILT)) rd_mux = CTR_W'({span_all, match_sid});
    if (rd_addr == AW'(A_CTRL)) rd_mux = CTR_W'({sec_obs, 1'b0});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

endmodule

// File: rtl/evt_cnt_group_chk.sv
module evt_cnt_group_chk #(
  parameter int unsigned NUM_CTR  = 4,
  parameter int unsigned NUM_EVT  = 16,
  parameter int unsigned CTR_W    = 32,
  parameter int unsigned AW       = 4,
  parameter int unsigned A_CTRL   = 11,
  parameter logic [15:0] SEC_MASK = 16'hF000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clk_gated,
  input logic               sec_obs,
  input logic               rd_en,
  input logic [AW-1:0]      rd_addr,
  input logic [CTR_W-1:0]   rd_data,
  input logic               rd_valid,
  input logic               wr_en,
  input logic [CTR_W-1:0]   wr_data,
  input logic [NUM_EVT-1:0] evt_qual,
  input logic [NUM_CTR-1:0] ctr_wrap,
  input logic [NUM_CTR-1:0] ctr_wr_hit,
  input logic [NUM_CTR-1:0] ovf_flag,
  input logic               cap_fire,
  input logic [CTR_W-1:0]   count  [NUM_CTR],
  input logic [CTR_W-1:0]   shadow [NUM_CTR]
);

  a_r3_gated_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    clk_gated |-> !evt_qual[0]);

  a_r6_secure_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_obs |-> ((evt_qual & NUM_EVT'(SEC_MASK)) == '0));

  a_r10_capture_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == AW'(A_CTRL)) |=> !rd_data[0]);

  a_r11_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  a_r11_valid_only_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_c
    a_r7_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_wrap[n] |=> ovf_flag[n]);

    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ctr_wr_hit[n]) |=> (count[n] == $past(wr_data)));

    a_r9_shadow_takes_count: assert property (@(posedge clk) disable iff (!rst_n)
      cap_fire |=> (shadow[n] == $past(count[n])));

    a_r9_shadow_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_fire |=> $stable(shadow[n]));
  end

endmodule

bind evt_cnt_group evt_cnt_group_chk #(
  .NUM_CTR(NUM_CTR), .NUM_EVT(NUM_EVT), .CTR_W(CTR_W), .AW(AW),
  .A_CTRL(A_CTRL), .SEC_MASK(SEC_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_gated(clk_gated), .sec_obs(sec_obs),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
  .wr_en(wr_en), .wr_data(wr_data), .evt_qual(evt_qual),
  .ctr_wrap(ctr_wrap), .ctr_wr_hit(ctr_wr_hit), .ovf_flag(ovf_flag),
  .cap_fire(cap_fire), .count(count), .shadow(shadow)
);

// File: tb/tb_evt_cnt_group.sv
module tb_evt_cnt_group;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:1]   evt_pulse = '0;
  logic [127:8]  evt_sid = '0;
  logic          clk_gated = 1'b1;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          rd_en = 1'b0;
  logic [3:0]    rd_addr = '0;
  logic [31:0]   rd_data;
  logic          rd_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;  // 250 MHz

  evt_cnt_group dut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .evt_sid(evt_sid),
    .clk_gated(clk_gated), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // Monitor: pop expected read results as the design delivers them
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11: unexpected rd_valid, data %h, expected no result", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: rd_data %h, expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
    checks++;
    if (rd_valid !== 1'b1) begin
      errors++;
      $display("FAIL R11: rd_valid %b one cycle after request, expected 1", rd_valid);
    end
  endtask

  task automatic pulse(input int code, input logic [7:0] sid, input int n);
    @(negedge clk);
    evt_pulse[code] = 1'b1;
    evt_sid[code*8 +: 8] = sid;
    repeat (n) @(negedge clk);
    evt_pulse[code] = 1'b0;
  endtask

  // Write and event pulse presented in the same cycle
  task automatic wr_with_pulse(input logic [3:0] a, input logic [31:0] d, input int code);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    evt_pulse[code] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    evt_pulse[code] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: everything reads 0 after reset
    for (int a = 0; a < 16; a++) rd(4'(a), 32'h0, "R1");

    // R3: cycle event counts only while clk_gated is low
    wr(4'd4, 32'd0);
    wr(4'd8, 32'h1);
    @(negedge clk); clk_gated = 1'b0;
    repeat (10) @(negedge clk);
    clk_gated = 1'b1;
    rd(4'd0, 32'd10, "R3");
    repeat (5) @(negedge clk);
    rd(4'd0, 32'd10, "R3");

    // R4/R2: shared filter on filterable code 3
    wr(4'd5, 32'd3);
    wr(4'd6, 32'd3);
    wr(4'd7, 32'd3);
    wr(4'd10, 32'h05A);
    wr(4'd8, 32'h6);
    pulse(3, 8'h5A, 4);
    pulse(3, 8'h11, 3);
    rd(4'd1, 32'd4, "R4");
    rd(4'd2, 32'd4, "R4");
    wr(4'd10, 32'h15A);
    pulse(3, 8'h11, 2);
    rd(4'd1, 32'd6, "R4");
    rd(4'd2, 32'd6, "R4");
    rd(4'd3, 32'd0, "R2");
    rd(4'd0, 32'd10, "R2");

    // R5: non-filterable code 9 ignores a mismatching filter
    wr(4'd10, 32'h05A);
    wr(4'd4, 32'd9);
    wr(4'd8, 32'h1);
    pulse(9, 8'h22, 5);
    rd(4'd0, 32'd15, "R5");
    rd(4'd1, 32'd6, "R2");

    // R6: secure code 13 needs the observation bit
    wr(4'd4, 32'd13);
    pulse(13, 8'h00, 3);
    rd(4'd0, 32'd15, "R6");
    wr(4'd11, 32'h2);
    pulse(13, 8'h00, 3);
    rd(4'd0, 32'd18, "R6");

    // R9/R10: coherent capture
    wr(4'd11, 32'h3);
    rd(4'd12, 32'd18, "R9");
    rd(4'd13, 32'd6, "R9");
    rd(4'd14, 32'd6, "R9");
    rd(4'd15, 32'd0, "R9");
    rd(4'd11, 32'h2, "R10");
    pulse(13, 8'h00, 3);
    rd(4'd12, 32'd18, "R9");
    wr_with_pulse(4'd11, 32'h3, 13);
    rd(4'd12, 32'd21, "R9");
    rd(4'd0, 32'd22, "R9");

    // R7: wrap, sticky flag, write-1 clear, set beats clear
    wr(4'd0, 32'hFFFF_FFFE);
    pulse(13, 8'h00, 2);
    rd(4'd0, 32'd0, "R7");
    rd(4'd9, 32'h1, "R7");
    wr(4'd9, 32'h1);
    rd(4'd9, 32'h0, "R7");
    wr(4'd0, 32'hFFFF_FFFF);
    wr_with_pulse(4'd9, 32'h1, 13);
    rd(4'd9, 32'h1, "R7");
    rd(4'd0, 32'd0, "R7");

    // R8: counter write beats a same-cycle increment
    wr_with_pulse(4'd0, 32'd100, 13);
    rd(4'd0, 32'd100, "R8");
    rd(4'd9, 32'h1, "R8");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11: %0d reads without result, expected 0", exp_q.size());
    end
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule